// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Mask Unit

This block gathers event signals from an I2C controller's FIFO logic and packet engine into a sticky status register. A mask register enables each status bit onto a single interrupt line. Software clears events by writing a 1 to each bit it wants cleared. If software writes back the value it just read, exactly the events it saw are cleared.

A second, wrapper-level status bit follows the masked interrupt condition. It has its own enable bit, so a controller placed behind an alternate register map can signal through one more level of status. All four registers are reached through a simple select, write strobe, write data and read data port.

Top module: `evt_irq_unit`

## Requirements
- R1: While reset is high at a clock edge, status, mask, wrapper enable, wrapper done and the interrupt output are all cleared to zero.
- R2: Status bits 6 (all packets done), 5 (TX FIFO overflow), 4 (RX FIFO underflow), 3 (no acknowledge) and 2 (arbitration lost) become 1 on the edge that samples their event input high. They then stay 1 until cleared.
- R3: A write to select 0 (status) clears each sticky status bit whose write-data bit is 1 and leaves every other bit unchanged.
- R4: An event and a clearing write on the same bit in the same cycle leave that bit set.
- R5: Status bit 7 (packet complete) is set by its event only when the per-packet enable input is high in the same cycle.
- R6: Status bits 1 (TX data request) and 0 (RX data request) show their request inputs one cycle later. A clearing write has no effect on them.
- R7: The mask register at select 1 uses the status bit layout in bits 7:0. The interrupt output rises one cycle after any status bit and its mask bit are both 1.
- R8: The wrapper done bit, read at bit 30 of select 3, is set one cycle after any masked status bit is active. It holds until a write to select 3 with bit 30 set.
- R9: The wrapper enable bit, stored from bit 30 of a write to select 2, routes the wrapper done bit onto the interrupt output one cycle later.
- R10: Read bits that hold no register field return zero: bits 31:8 of selects 0 and 1, and every bit except 30 of selects 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Event inputs in status bit layout; bits 1:0 are levels, the rest pulses |
| pkt_ie_i | input | 1 | Per-packet enable for the packet-complete event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 wrapper enable, 3 wrapper status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and the wrapper field at bit 30. These defaults make both the eight-bit status layout and the wrapper path observable. Directed sequences cover set-over-clear collisions, packet-complete gating, and the one-cycle lag of the interrupt behind the mask and behind the wrapper enable. A long random phase then mixes events with writes to every select. A behavioural model predicts the interrupt output and the selected read data on every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int EVT_N    = 8;
    localparam int SEL_W    = 2;
    localparam int PKT_BIT  = 7;
    localparam logic [EVT_N-1:0] LEVEL_BITS = 8'b0000_0011;

    typedef enum logic [SEL_W-1:0] {
        SEL_STAT  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_WCTL  = 2'd2,
        SEL_WSTAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic stat;
        logic mask;
        logic wctl;
        logic wstat;
    } wr_strobe_t;

    // Packet-complete may only set when the per-packet enable is high.
    function automatic logic [EVT_N-1:0] gate_events(input logic [EVT_N-1:0] ev,
                                                     input logic pkt_ie);
        logic [EVT_N-1:0] r;
        r = ev;
        r[PKT_BIT] = ev[PKT_BIT] & pkt_ie;
        return r;
    endfunction
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
    import evt_irq_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    output wr_strobe_t       strobe
);
    always_comb begin
        strobe = '0;
        if (wr_en) begin
            case (reg_sel_e'(sel))
                SEL_STAT:  strobe.stat  = 1'b1;
                SEL_MASK:  strobe.mask  = 1'b1;
                SEL_WCTL:  strobe.wctl  = 1'b1;
                default:   strobe.wstat = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/evt_irq_wrap.sv
module evt_irq_wrap (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic stat_wr,
    input  logic wbit,
    input  logic any_masked,
    output logic en_o,
    output logic done_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= 1'b0;
            done_o <= 1'b0;
        end else begin
            if (ctl_wr)
                en_o <= wbit;
            done_o <= any_masked | (done_o & ~(stat_wr & wbit));
        end
    end
endmodule

// File: rtl/evt_irq_readmux.sv
module evt_irq_readmux
    import evt_irq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int WRAP_BIT = 30
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [EVT_N-1:0]  stat,
    input  logic [EVT_N-1:0]  mask,
    input  logic              wen,
    input  logic              wdone,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_STAT:  rdata[EVT_N-1:0] = stat;
            SEL_MASK:  rdata[EVT_N-1:0] = mask;
            SEL_WCTL:  rdata[WRAP_BIT]  = wen;
            default:   rdata[WRAP_BIT]  = wdone;
        endcase
    end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int WRAP_BIT = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              pkt_ie_i,
    input  logic              reg_wr_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    wr_strobe_t       strobe;
    logic [EVT_N-1:0] ev_g;
    logic [EVT_N-1:0] stat_q;
    logic [EVT_N-1:0] mask_q;
    logic             wen_q;
    logic             wdone_q;
    logic             any_masked;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata_i[DATA_W-1:WRAP_BIT+1],
                            reg_wdata_i[WRAP_BIT-1:EVT_N]};

    evt_irq_decode u_dec (
        .wr_en  (reg_wr_i),
        .sel    (reg_sel_i),
        .strobe (strobe)
    );

    assign ev_g = gate_events(evt_i, pkt_ie_i);

    // Per-bit status cells: request bits track their source, others are sticky.
    for (genvar i = 0; i < EVT_N; i++) begin : g_stat
        if (LEVEL_BITS[i]) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) stat_q[i] <= 1'b0;
                else     stat_q[i] <= ev_g[i];
            end
        end else begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) stat_q[i] <= 1'b0;
                else     stat_q[i] <= ev_g[i] |
                                      (stat_q[i] & ~(strobe.stat & reg_wdata_i[i]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              mask_q <= '0;
        else if (strobe.mask) mask_q <= reg_wdata_i[EVT_N-1:0];
    end

    assign any_masked = |(stat_q & mask_q);

    evt_irq_wrap u_wrap (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (strobe.wctl),
        .stat_wr    (strobe.wstat),
        .wbit       (reg_wdata_i[WRAP_BIT]),
        .any_masked (any_masked),
        .en_o       (wen_q),
        .done_o     (wdone_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= any_masked | (wdone_q & wen_q);
    end

    evt_irq_readmux #(.DATA_W(DATA_W), .WRAP_BIT(WRAP_BIT)) u_rmux (
        .sel   (reg_sel_i),
        .stat  (stat_q),
        .mask  (mask_q),
        .wen   (wen_q),
        .wdone (wdone_q),
        .rdata (reg_rdata_o)
    );
endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker
    import evt_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [EVT_N-1:0] evt_i,
    input logic             pkt_ie_i,
    input logic             reg_wr_i,
    input logic [SEL_W-1:0] reg_sel_i,
    input logic [EVT_N-1:0] wd_lo,
    input logic [EVT_N-1:0] stat_q,
    input logic [EVT_N-1:0] mask_q,
    input logic             wen_q,
    input logic             wdone_q,
    input logic             irq_o
);
    logic             armed;
    logic [EVT_N-1:0] clr_v;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assign clr_v = (reg_wr_i && reg_sel_i == SEL_STAT) ? wd_lo : '0;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && mask_q == '0 && !irq_o && !wen_q && !wdone_q));

    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        (($past(stat_q & ~clr_v) & ~LEVEL_BITS & ~stat_q) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        ((gate_events($past(evt_i), $past(pkt_ie_i)) & ~LEVEL_BITS & ~stat_q) == '0));

    p_pkt_gate_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        (evt_i[PKT_BIT] && !pkt_ie_i && !stat_q[PKT_BIT]) |=> !stat_q[PKT_BIT]);

    p_level_track_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        (stat_q[1:0] == $past(evt_i[1:0])));

    p_irq_on_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        (|(stat_q & mask_q)) |=> irq_o);

    p_irq_off_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        (!(|(stat_q & mask_q)) && !(wdone_q && wen_q)) |=> !irq_o);

    p_done_set_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (|(stat_q & mask_q)) |=> wdone_q);

    p_done_route_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        (wdone_q && wen_q) |=> irq_o);
endmodule

bind evt_irq_unit evt_irq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .pkt_ie_i  (pkt_ie_i),
    .reg_wr_i  (reg_wr_i),
    .reg_sel_i (reg_sel_i),
    .wd_lo     (reg_wdata_i[7:0]),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .wen_q     (wen_q),
    .wdone_q   (wdone_q),
    .irq_o     (irq_o)
);

// File: tb/sim_evt_irq_unit.sv
module sim_evt_irq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt = '0;
    logic        pkt_ie = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    evt_irq_unit u0 (
        .clk (clk), .rst (rst), .evt_i (evt), .pkt_ie_i (pkt_ie),
        .reg_wr_i (reg_wr), .reg_sel_i (reg_sel), .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata), .irq_o (irq)
    );

    // Behavioural reference state
    logic [7:0] m_st, m_mask;
    logic       m_en, m_done, m_irq;

    function automatic logic [7:0] next_status(input logic [7:0] cur, input logic [7:0] ev,
                                               input logic ie, input logic clr,
                                               input logic [7:0] wd);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (i < 2) r[i] = ev[i];
            else r[i] = (ev[i] && (i != 7 || ie)) || (cur[i] && !(clr && wd[i]));
        end
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] s);
        logic [31:0] r;
        r = '0;
        case (s)
            2'd0: r[7:0] = m_st;
            2'd1: r[7:0] = m_mask;
            2'd2: r[30]  = m_en;
            default: r[30] = m_done;
        endcase
        return r;
    endfunction

    function automatic string sel_tag(input logic [1:0] s);
        case (s)
            2'd0: return "R3 status";
            2'd1: return "R7 mask";
            2'd2: return "R9 wrapper enable";
            default: return "R8 wrapper done";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st <= '0; m_mask <= '0; m_en <= 1'b0; m_done <= 1'b0; m_irq <= 1'b0;
        end else begin
            m_st   <= next_status(m_st, evt, pkt_ie, reg_wr && reg_sel == 2'd0, reg_wdata[7:0]);
            if (reg_wr && reg_sel == 2'd1) m_mask <= reg_wdata[7:0];
            if (reg_wr && reg_sel == 2'd2) m_en <= reg_wdata[30];
            m_done <= (|(m_st & m_mask)) || (m_done && !(reg_wr && reg_sel == 2'd3 && reg_wdata[30]));
            m_irq  <= (|(m_st & m_mask)) || (m_done && m_en);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            #2;
            check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
            check(sel_tag(reg_sel), reg_rdata, model_read(reg_sel));
        end
    end

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] s, input logic [31:0] exp);
        reg_sel = s;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [7:0] b);
        @(negedge clk);
        evt = evt | b;
        @(negedge clk);
        evt = evt & ~b;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1: reset state
        rd_chk("R1 status", 2'd0, 32'h0);
        rd_chk("R1 mask", 2'd1, 32'h0);
        rd_chk("R1 wrapper enable", 2'd2, 32'h0);
        rd_chk("R1 wrapper done", 2'd3, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2: sticky event holds
        pulse(8'h20);
        rd_chk("R2 overflow set", 2'd0, 32'h20);
        repeat (3) @(negedge clk);
        rd_chk("R2 overflow held", 2'd0, 32'h20);

        // R3: write-one-to-clear exact bits
        wr_reg(2'd0, 32'h20);
        rd_chk("R3 clear one", 2'd0, 32'h0);
        pulse(8'h1C);
        rd_chk("R2 three events", 2'd0, 32'h1C);
        wr_reg(2'd0, 32'h08);
        rd_chk("R3 partial clear", 2'd0, 32'h14);
        wr_reg(2'd0, 32'hFF);
        rd_chk("R3 clear all", 2'd0, 32'h0);

        // R4: event wins over simultaneous clear
        @(negedge clk);
        evt = 8'h40; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h40;
        @(negedge clk);
        evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd_chk("R4 set wins", 2'd0, 32'h40);
        wr_reg(2'd0, 32'h40);

        // R5: packet-complete gating
        pkt_ie = 1'b0;
        pulse(8'h80);
        rd_chk("R5 gated off", 2'd0, 32'h0);
        pkt_ie = 1'b1;
        pulse(8'h80);
        rd_chk("R5 gated on", 2'd0, 32'h80);
        wr_reg(2'd0, 32'h80);
        pkt_ie = 1'b0;

        // R6: level-tracking request bits
        @(negedge clk); evt[1] = 1'b1;
        @(negedge clk);
        rd_chk("R6 tx request visible", 2'd0, 32'h02);
        wr_reg(2'd0, 32'h02);
        rd_chk("R6 clear ignored", 2'd0, 32'h02);
        evt[1] = 1'b0;
        @(negedge clk);
        rd_chk("R6 tx request dropped", 2'd0, 32'h0);
        pulse(8'h01);
        rd_chk("R6 rx request visible", 2'd0, 32'h01);
        @(negedge clk);
        rd_chk("R6 rx request dropped", 2'd0, 32'h0);

        // R7: mask and interrupt latency
        pulse(8'h08);
        check("R7 masked off", {31'b0, irq}, 32'h0);
        wr_reg(2'd1, 32'h08);
        check("R7 one cycle lag", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R7 irq raised", {31'b0, irq}, 32'h1);
        wr_reg(2'd1, 32'h00);
        @(negedge clk);
        check("R7 irq dropped", {31'b0, irq}, 32'h0);

        // R8: wrapper done set and cleared
        rd_chk("R8 done set", 2'd3, 32'h4000_0000);
        wr_reg(2'd3, 32'h4000_0000);
        rd_chk("R8 done cleared", 2'd3, 32'h0);

        // R9 / R10: wrapper enable routes done to irq
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_chk("R10 enable read", 2'd2, 32'h4000_0000);
        wr_reg(2'd1, 32'h08);
        @(negedge clk);
        wr_reg(2'd1, 32'h00);
        wr_reg(2'd0, 32'h08);
        check("R9 irq held by done", {31'b0, irq}, 32'h1);
        wr_reg(2'd3, 32'h4000_0000);
        @(negedge clk);
        check("R9 irq released", {31'b0, irq}, 32'h0);
        wr_reg(2'd1, 32'hFFFF_FF5A);
        rd_chk("R10 mask upper zero", 2'd1, 32'h0000_005A);
        wr_reg(2'd1, 32'h0);

        // Random phase, compared each cycle against the model
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            evt       = 8'($urandom) & 8'($urandom) & 8'($urandom);
            pkt_ie    = 1'($urandom);
            reg_wr    = ($urandom % 5) == 0;
            reg_sel   = 2'($urandom);
            reg_wdata = $urandom;
        end
        @(negedge clk);
        evt = '0; reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        #3;
        finish_run();
    end
endmodule